// File: doc/BRIEF.md
# Chained Interrupt Acknowledge Arbiter with Priority Groups

This block sits between a set of interrupt sources and a processor. The sources are divided into priority groups, and each group holds a fixed number of slots. A slot is raised by a one-cycle set pulse and then stays pending. Each group drives a request line that is the OR of all pending slots in that group. When the processor acknowledges, the arbiter forwards the acknowledge to one group. Inside that group the acknowledge travels from slot 0 upward, and the first pending slot it meets keeps it. That slot clears its pending flag, and its flat index is sent out as a vector.

Group 0 has the highest priority. An acknowledge is forwarded only to a group whose priority is above every group currently being serviced, so a higher group can nest on top of a lower one. An in-service mark is set for a group when its acknowledge is accepted. An end-of-service pulse removes the mark of the highest-priority group in service.

The vector leaves on a valid/ready stream. The vector stays valid, with a stable value, until the consumer takes it with ready high. While a vector is waiting like this, further acknowledges are refused. Slots are fixed in priority and are not rotated, so a slot near the end of the chain can wait forever while slots ahead of it keep requesting.

Top module: `irq_daisy_arbiter`

## Requirements
- R1: A set pulse on `req_set_i[k]` makes slot k pending from the next cycle, and it stays pending until slot k wins an acknowledge. `grp_req_o[g]` is high exactly when at least one slot with index g*SLOTS to g*SLOTS+SLOTS-1 is pending.
- R2: Inside the granted group, the pending slot with the lowest local index wins.
- R3: On the clock edge where an acknowledge is accepted, the winning slot stops pending. From the next cycle, `vec_valid_o` is 1 and `vec_id_o` equals g*SLOTS plus the winner's local index.
- R4: If `ack_i` arrives while no eligible group requests, no vector is produced, no pending flag changes and `in_service_o` does not change.
- R5: A group g is eligible only when `grp_req_o[g]` is high and no group with index at or below g is in service. The acknowledge goes to the eligible group with the lowest index, and `grp_ack_o` shows that group combinationally in the same cycle.
- R6: An accepted acknowledge to group g sets `in_service_o[g]` on the next cycle. A pulse on `eos_i` clears the lowest-index set bit of `in_service_o`. If both happen in the same cycle, the pop is applied first and then the push.
- R7: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_id_o` holds its value, `grp_ack_o` is all zero, and `ack_i` is ignored. The vector is consumed on a cycle where both `vec_valid_o` and `vec_ready_i` are high.
- R8: If a set pulse reaches a slot in the same cycle that the slot wins, the slot stays pending.
- R9: At most one bit of `grp_ack_o` is high at any time.
- R10: After reset, no slot is pending, `in_service_o` is zero and `vec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_i | input | GROUPS*SLOTS | One-cycle pulses that make a slot pending |
| ack_i | input | 1 | Acknowledge from the processor |
| eos_i | input | 1 | End of service for the current level |
| grp_req_o | output | GROUPS | Per-group OR of the pending slots |
| grp_ack_o | output | GROUPS | Acknowledge forwarded to a group (combinational) |
| in_service_o | output | GROUPS | Groups currently marked as being serviced |
| vec_valid_o | output | 1 | Vector stream valid |
| vec_ready_i | input | 1 | Vector stream ready |
| vec_id_o | output | $clog2(GROUPS*SLOTS) | Flat index of the slot that won |

## Verification
The bench walks through every non-empty pending pattern of each group and drains each pattern one acknowledge at a time. A chain that gets its order wrong returns a higher slot before a lower one. A chain that fails to clear the winner returns the same slot again. The bench also covers these cases:
- An acknowledge of a lower group while a higher group is in service. A design that does this emits a vector it should not.
- A higher group nesting on top of a lower one, followed by end-of-service. A design that pops the wrong level leaves the wrong group marked.
- An acknowledge that arrives while a vector is stalled. A design that accepts it overwrites the waiting vector.
- A set pulse that collides with the clear of the same slot. A design that gets this wrong loses the new request.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;

  localparam int unsigned MAX_GROUPS = 32;

  // keep only the lowest set bit of a vector
  function automatic logic [MAX_GROUPS-1:0] low_bit(input logic [MAX_GROUPS-1:0] v);
    return v & (~v + 1'b1);
  endfunction

endpackage

// File: rtl/irq_slot_chain.sv
module irq_slot_chain #(
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  set_i,
  input  logic              ack_in,
  output logic              req_o,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic [SLOTS-1:0] pend_q;
  logic [SLOTS:0]   pass;
  logic [SLOTS-1:0] take;

  assign pass[0] = ack_in;

  // acknowledge ripples from slot 0 upward; the first pending slot keeps it
  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_link
      assign take[i]   = pass[i] & pend_q[i];
      assign pass[i+1] = pass[i] & ~pend_q[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~take) | set_i;
  end

  always_comb begin
    slot_o = '0;
    for (int i = 0; i < SLOTS; i++)
      if (take[i]) slot_o = slot_o | SLOT_W'(i);
  end

  assign req_o = |pend_q;
  assign hit_o = |take;

endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
  import irq_daisy_pkg::*;
#(
  parameter int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUPS-1:0] grp_req_i,
  input  logic              ack_i,
  input  logic              eos_i,
  output logic [GROUPS-1:0] grp_ack_o,
  output logic [GROUPS-1:0] insvc_o
);

  logic [GROUPS-1:0] insvc_q;
  logic [GROUPS-1:0] open_lvl;
  logic [GROUPS-1:0] elig;
  logic [GROUPS-1:0] grant;
  logic [GROUPS-1:0] pop;
  logic [MAX_GROUPS-1:0] grant_w;
  logic [MAX_GROUPS-1:0] pop_w;

  // group g is open when nothing at index <= g is in service
  assign open_lvl[0] = ~insvc_q[0];
  generate
    for (genvar g = 1; g < GROUPS; g++) begin : g_open
      assign open_lvl[g] = open_lvl[g-1] & ~insvc_q[g];
    end
  endgenerate

  assign elig    = grp_req_i & open_lvl;
  assign grant_w = low_bit(MAX_GROUPS'(elig));
  assign grant   = grant_w[GROUPS-1:0];
  assign pop_w   = low_bit(MAX_GROUPS'(insvc_q));
  assign pop     = eos_i ? pop_w[GROUPS-1:0] : '0;

  assign grp_ack_o = ack_i ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) insvc_q <= '0;
    else        insvc_q <= (insvc_q & ~pop) | grp_ack_o;
  end

  assign insvc_o = insvc_q;

endmodule

// File: rtl/irq_daisy_arbiter.sv
module irq_daisy_arbiter #(
  parameter int GROUPS = 2,
  parameter int SLOTS  = 4,
  localparam int NSLOT  = GROUPS * SLOTS,
  localparam int ID_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  req_set_i,
  input  logic              ack_i,
  input  logic              eos_i,
  output logic [GROUPS-1:0] grp_req_o,
  output logic [GROUPS-1:0] grp_ack_o,
  output logic [GROUPS-1:0] in_service_o,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [ID_W-1:0]   vec_id_o
);

  logic                     stall;
  logic                     ack_go;
  logic [GROUPS-1:0]        hit;
  logic [GROUPS*SLOT_W-1:0] slot_flat;
  logic [ID_W-1:0]          win_id;
  logic                     vld_q;
  logic [ID_W-1:0]          id_q;

  assign stall  = vld_q & ~vec_ready_i;
  assign ack_go = ack_i & ~stall;

  irq_group_arb #(.GROUPS(GROUPS)) u_garb (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_req_i (grp_req_o),
    .ack_i     (ack_go),
    .eos_i     (eos_i),
    .grp_ack_o (grp_ack_o),
    .insvc_o   (in_service_o)
  );

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      irq_slot_chain #(.SLOTS(SLOTS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_set_i[g*SLOTS +: SLOTS]),
        .ack_in (grp_ack_o[g]),
        .req_o  (grp_req_o[g]),
        .hit_o  (hit[g]),
        .slot_o (slot_flat[g*SLOT_W +: SLOT_W])
      );
    end
  endgenerate

  always_comb begin
    win_id = '0;
    for (int g = 0; g < GROUPS; g++)
      if (hit[g])
        win_id = ID_W'(g * SLOTS) + ID_W'(slot_flat[g*SLOT_W +: SLOT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (vld_q && vec_ready_i) vld_q <= 1'b0;
      if (|hit) begin
        vld_q <= 1'b1;
        id_q  <= win_id;
      end
    end
  end

  assign vec_valid_o = vld_q;
  assign vec_id_o    = id_q;

endmodule

// File: rtl/irq_daisy_arbiter_chk.sv
module irq_daisy_arbiter_chk #(
  parameter int GROUPS = 2,
  parameter int SLOTS  = 4,
  localparam int NSLOT = GROUPS * SLOTS,
  localparam int ID_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic [GROUPS-1:0] grp_req_o,
  input logic [GROUPS-1:0] grp_ack_o,
  input logic [GROUPS-1:0] in_service_o,
  input logic              vec_valid_o,
  input logic              vec_ready_i,
  input logic [ID_W-1:0]   vec_id_o
);

  logic [GROUPS:0] ack_ext;
  logic [GROUPS:0] upto;
  assign ack_ext = {1'b0, grp_ack_o};
  assign upto    = (ack_ext << 1) - 1'b1;

  // R9
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_ack_o));

  // R5
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_ack_o) |-> ((upto[GROUPS-1:0] & in_service_o) == '0));

  // R6
  push_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_ack_o) |=> ((in_service_o & $past(grp_ack_o)) != '0));

  // R3
  vec_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_ack_o) |=> vec_valid_o);

  // R4
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && grp_req_o == '0 && !vec_valid_o) |=> !vec_valid_o);

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_id_o)));

  // R7
  stall_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |-> (grp_ack_o == '0));

endmodule

bind irq_daisy_arbiter irq_daisy_arbiter_chk #(.GROUPS(GROUPS), .SLOTS(SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_i        (ack_i),
  .grp_req_o    (grp_req_o),
  .grp_ack_o    (grp_ack_o),
  .in_service_o (in_service_o),
  .vec_valid_o  (vec_valid_o),
  .vec_ready_i  (vec_ready_i),
  .vec_id_o     (vec_id_o)
);

// File: tb/irq_daisy_arbiter_tb.sv
module irq_daisy_arbiter_tb;
  localparam int G  = 2;
  localparam int S  = 4;
  localparam int N  = G * S;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_set_i = '0;
  logic          ack_i = 1'b0;
  logic          eos_i = 1'b0;
  logic          vec_ready_i = 1'b0;
  logic [G-1:0]  grp_req_o, grp_ack_o, in_service_o;
  logic          vec_valid_o;
  logic [IW-1:0] vec_id_o;
  logic [G-1:0]  ga_seen;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_daisy_arbiter #(.GROUPS(G), .SLOTS(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_set_i(req_set_i), .ack_i(ack_i), .eos_i(eos_i),
    .grp_req_o(grp_req_o), .grp_ack_o(grp_ack_o), .in_service_o(in_service_o),
    .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i), .vec_id_o(vec_id_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [N-1:0] m);
    @(negedge clk); req_set_i = m;
    @(posedge clk); @(negedge clk); req_set_i = '0;
  endtask

  task automatic pulse_ack(input logic [N-1:0] also_set);
    @(negedge clk); ack_i = 1'b1; req_set_i = also_set;
    #1 ga_seen = grp_ack_o;
    @(posedge clk); @(negedge clk); ack_i = 1'b0; req_set_i = '0;
  endtask

  task automatic pop_vec();
    vec_ready_i = 1'b1;
    @(posedge clk); @(negedge clk); vec_ready_i = 1'b0;
  endtask

  task automatic do_eos();
    @(negedge clk); eos_i = 1'b1;
    @(posedge clk); @(negedge clk); eos_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state
    chk("R10 vec_valid", int'(vec_valid_o), 0);
    chk("R10 grp_req", int'(grp_req_o), 0);
    chk("R10 in_service", int'(in_service_o), 0);

    // R4 acknowledge with nothing pending
    pulse_ack('0);
    chk("R4 grp_ack idle", int'(ga_seen), 0);
    chk("R4 vec_valid idle", int'(vec_valid_o), 0);
    chk("R4 in_service idle", int'(in_service_o), 0);

    // R1 R2 R3 R6 sweep of every pattern in every group
    for (int g = 0; g < G; g++) begin
      for (int p = 1; p < (1 << S); p++) begin
        int rem;
        rem = p;
        set_req(N'(p) << (g * S));
        chk("R1 grp_req after set", int'(grp_req_o), 1 << g);
        while (rem != 0) begin
          int lo;
          lo = 0;
          while (((rem >> lo) & 1) == 0) lo++;
          pulse_ack('0);
          chk("R5 grp_ack target", int'(ga_seen), 1 << g);
          chk("R3 vec_valid", int'(vec_valid_o), 1);
          chk("R2 winner id", int'(vec_id_o), g * S + lo);
          chk("R6 push mark", int'(in_service_o), 1 << g);
          pop_vec();
          do_eos();
          chk("R6 pop mark", int'(in_service_o), 0);
          rem = rem & ~(1 << lo);
        end
        chk("R3 all cleared", int'(grp_req_o), 0);
        chk("R7 consumed", int'(vec_valid_o), 0);
      end
    end

    // R5 lower group blocked while higher is serviced, then nesting
    set_req(N'(1 << 5) | N'(1 << 2));
    pulse_ack('0);
    chk("R5 high group first", int'(vec_id_o), 2);
    chk("R6 mark g0", int'(in_service_o), 1);
    pop_vec();
    pulse_ack('0);
    chk("R5 lower blocked ack", int'(ga_seen), 0);
    chk("R5 lower blocked vec", int'(vec_valid_o), 0);
    chk("R4 req kept", int'(grp_req_o), 2);
    do_eos();
    pulse_ack('0);
    chk("R5 g1 after eos", int'(vec_id_o), 5);
    chk("R6 mark g1", int'(in_service_o), 2);
    pop_vec();
    set_req(N'(1 << 3));
    pulse_ack('0);
    chk("R5 nested id", int'(vec_id_o), 3);
    chk("R6 nested marks", int'(in_service_o), 3);
    pop_vec();
    do_eos();
    chk("R6 pop lowest", int'(in_service_o), 2);
    do_eos();
    chk("R6 pop last", int'(in_service_o), 0);

    // R7 back-pressure
    set_req(N'(3));
    pulse_ack('0);
    chk("R7 first vec", int'(vec_id_o), 0);
    do_eos();
    pulse_ack('0);
    chk("R7 stalled ack", int'(ga_seen), 0);
    chk("R7 held valid", int'(vec_valid_o), 1);
    chk("R7 held id", int'(vec_id_o), 0);
    chk("R7 req intact", int'(grp_req_o), 1);
    chk("R7 no mark", int'(in_service_o), 0);
    pop_vec();
    chk("R7 drained", int'(vec_valid_o), 0);
    pulse_ack('0);
    chk("R7 next vec", int'(vec_id_o), 1);
    pop_vec();
    do_eos();

    // R8 set collides with clear of the same slot
    set_req(N'(1 << 6));
    pulse_ack(N'(1 << 6));
    chk("R8 id", int'(vec_id_o), 6);
    chk("R8 still pending", int'(grp_req_o), 2);
    pop_vec();
    do_eos();
    pulse_ack('0);
    chk("R8 served again", int'(vec_id_o), 6);
    chk("R8 now clear", int'(grp_req_o), 0);
    pop_vec();
    do_eos();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule